// File: doc/BRIEF.md
# Serial Peripheral Port Controller with Completion and Collision Flags

This block is a byte-wide serial peripheral (SPI) port that can act either as the clock-driving master or as a selected slave. Software talks to it over a small synchronous register bus: a control register picks the role, the SCK rate and the interrupt enable; a status register reports transfer completion and write collisions and holds the double-speed bit; a data register starts a transfer when written and returns the received byte when read. Frames are 8 bits, most significant bit first, with SCK idle low, outgoing data changing on the falling SCK edge and incoming data captured on the rising edge.

In master mode the block derives SCK from the system clock through a prescaler with seven distinct ratios. In slave mode the external SCK, select and MOSI lines are passed through two-stage synchronisers before edge detection. The completion flag can raise an interrupt request; it is cleared either by an acknowledge pulse or by reading the status register and then touching the data register. Writing the data register while a frame is moving sets a collision flag, drops the written byte and leaves the frame untouched. If the select input is used as an input while in master mode, a falling edge on it sets the completion flag.

Top module: `spi_ctl`

## Requirements
- R1: When an 8-bit frame finishes (master or slave), status bit 7 (completion flag) becomes 1.
- R2: `irq` is high exactly when the completion flag, control bit 7 (interrupt enable) and the `gie` input are all 1.
- R3: With control bits 6 (enable), 4 (master) and 3 (select-is-input) set, a falling edge on `ss_n_i` sets the completion flag.
- R4: A one-cycle pulse on `irq_ack` clears the completion flag.
- R5: A status read (address 1) that sees the completion flag set, followed later by a read or write of the data register (address 2), clears the completion flag; a status read that sees it clear arms nothing, so a later data access leaves a newly set flag alone.
- R6: Writing address 2 while a frame is in progress sets status bit 6 (collision flag); the written byte is discarded and the ongoing frame sends and receives its original bytes.
- R7: A status read that sees the collision flag set, followed by a data-register access, clears both status bit 6 and status bit 7.
- R8: Status bits 5 to 1 always read 0; status bit 0 (double speed) is writable and readable; control, status and data all read 0 after reset.
- R9: In master mode the SCK period, for control bits 1:0 = 0,1,2,3, is 4, 16, 64, 128 system clocks with double speed clear, and 2, 8, 32, 64 with it set.
- R10: In master mode the byte written to address 2 appears on `mosi_o` MSB first, and the byte shifted in from `miso_i` is read back from address 2 after completion; `sck_o` is low whenever no master frame is active.
- R11: In slave mode (bit 6 set, bit 4 clear) with `ss_n_i` low and external SCK no faster than one eighth of the system clock, the byte on `mosi_i` is received and the byte last written to address 2 is sent on `miso_o`, MSB first.
- R12: In master mode with bit 3 clear, `ss_n_o` is low while a frame is active and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle `rd_en` is high, else 0 |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the completion flag |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_i | input | 1 | Serial data in for master mode |
| ss_n_i | input | 1 | Select input (slave select, or fault input in master mode) |
| ss_n_o | output | 1 | Select output driven in master mode |

## Verification
The properties assume bus strobes are single-cycle and never read and write in the same cycle, that `irq_ack` is a short pulse, and that a slave-mode SCK changes no faster than every four system clocks with MOSI changing only after falling edges. The bench drives every bus access as one isolated cycle aligned to the falling clock edge, models the external slave as a shift register clocked by `sck_o`, and generates its own slave-mode SCK with four-cycle half periods. It sweeps all eight rate settings with distinct byte pairs and places the collision write and the select-pin toggles only where the requirements define the outcome.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  localparam int FRAME_W = 8;
  localparam int HCNT_W  = 7;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_DATA = 2'd2;

  localparam int CB_IRQ_EN = 7;
  localparam int CB_ENABLE = 6;
  localparam int CB_MASTER = 4;
  localparam int CB_SS_IN  = 3;

  // last count of one SCK half period, in system clocks
  function automatic logic [HCNT_W-1:0] half_limit(input logic dbl, input logic [1:0] rate);
    logic [2:0] e;
    logic [HCNT_W-1:0] one;
    case (rate)
      2'd0:    e = 3'd1;
      2'd1:    e = 3'd3;
      2'd2:    e = 3'd5;
      default: e = 3'd6;
    endcase
    e   = e - {2'b00, dbl};
    one = {{(HCNT_W-1){1'b0}}, 1'b1};
    return (one << e) - one;
  endfunction

endpackage

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = W * STAGES;

  logic [CW-1:0] chain_q;
  logic [CW-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[CW-W-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST}};
    else        chain_q <= chain_n;
  end

  assign q = chain_q[CW-1 -: W];
endmodule

// File: rtl/spi_ctl_rate.sv
module spi_ctl_rate
  import spi_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       dbl,
  input  logic [1:0] rate,
  output logic       tick
);
  logic [HCNT_W-1:0] cnt_q, cnt_n, lim;

  always_comb begin
    lim  = half_limit(dbl, rate);
    tick = run && (cnt_q == lim);
    if (!run || tick) cnt_n = '0;
    else              cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/spi_ctl_engine.sv
module spi_ctl_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ms,
  input  logic          load,
  input  logic [DW-1:0] ldata,
  input  logic          tick,
  input  logic          miso_i,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          ss_n_i,
  output logic          busy,
  output logic          m_busy,
  output logic          done,
  output logic          ss_fall,
  output logic [DW-1:0] shreg,
  output logic          sck_o,
  output logic          sd_o
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0] LAST = BW'(DW - 1);

  logic [DW-1:0] sreg_q, sreg_n;
  logic          samp_q, samp_n;
  logic [BW-1:0] bcnt_q, bcnt_n;
  logic          mbusy_q, mbusy_n;
  logic          sck_q, sck_n;
  logic          sckd_q, ssd_q;

  logic [2:0] pins_s;
  logic       ss_s, sck_s, mosi_s;
  logic       ss_sel, sck_rise, sck_fall;
  logic       m_on, s_on;

  spi_ctl_sync #(.W(3), .STAGES(2), .RST(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ss_n_i, sck_i, mosi_i}),
    .q     (pins_s)
  );

  assign ss_s   = pins_s[2];
  assign sck_s  = pins_s[1];
  assign mosi_s = pins_s[0];

  always_comb begin
    m_on     = en && ms;
    s_on     = en && !ms;
    ss_sel   = !ss_s;
    sck_rise = sck_s && !sckd_q;
    sck_fall = !sck_s && sckd_q;
    ss_fall  = !ss_s && ssd_q;
  end

  always_comb begin
    sreg_n  = sreg_q;
    samp_n  = samp_q;
    bcnt_n  = bcnt_q;
    mbusy_n = mbusy_q;
    sck_n   = sck_q;
    done    = 1'b0;
    if (m_on) begin
      if (mbusy_q) begin
        if (tick) begin
          if (!sck_q) begin
            sck_n  = 1'b1;
            samp_n = miso_i;
          end else begin
            sck_n  = 1'b0;
            sreg_n = {sreg_q[DW-2:0], samp_q};
            if (bcnt_q == LAST) begin
              bcnt_n  = '0;
              mbusy_n = 1'b0;
              done    = 1'b1;
            end else begin
              bcnt_n = bcnt_q + 1'b1;
            end
          end
        end
      end else if (load) begin
        sreg_n  = ldata;
        mbusy_n = 1'b1;
        sck_n   = 1'b0;
        bcnt_n  = '0;
      end
    end else begin
      mbusy_n = 1'b0;
      sck_n   = 1'b0;
      if (s_on) begin
        if (!ss_sel) begin
          bcnt_n = '0;
          if (load) sreg_n = ldata;
        end else begin
          if (sck_rise) samp_n = mosi_s;
          if (sck_fall) begin
            sreg_n = {sreg_q[DW-2:0], samp_q};
            if (bcnt_q == LAST) begin
              bcnt_n = '0;
              done   = 1'b1;
            end else begin
              bcnt_n = bcnt_q + 1'b1;
            end
          end
        end
      end else begin
        bcnt_n = '0;
        if (load) sreg_n = ldata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q  <= '0;
      samp_q  <= 1'b0;
      bcnt_q  <= '0;
      mbusy_q <= 1'b0;
      sck_q   <= 1'b0;
      sckd_q  <= 1'b0;
      ssd_q   <= 1'b1;
    end else begin
      sreg_q  <= sreg_n;
      samp_q  <= samp_n;
      bcnt_q  <= bcnt_n;
      mbusy_q <= mbusy_n;
      sck_q   <= sck_n;
      sckd_q  <= sck_s;
      ssd_q   <= ss_s;
    end
  end

  assign busy   = m_on ? mbusy_q : (s_on && ss_sel);
  assign m_busy = mbusy_q;
  assign shreg  = sreg_q;
  assign sck_o  = sck_q;
  assign sd_o   = sreg_q[DW-1];
endmodule

// File: rtl/spi_ctl_flags.sv
module spi_ctl_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic data_acc,
  input  logic irq_ack,
  input  logic set_cf,
  input  logic set_wc,
  output logic cf,
  output logic wc
);
  logic cf_q, cf_n, wc_q, wc_n;
  logic arm_cf_q, arm_cf_n, arm_wc_q, arm_wc_n;

  always_comb begin
    cf_n     = cf_q;
    wc_n     = wc_q;
    arm_cf_n = arm_cf_q;
    arm_wc_n = arm_wc_q;
    if (stat_rd) begin
      arm_cf_n = cf_q;
      arm_wc_n = wc_q;
    end else if (data_acc) begin
      if (arm_cf_q || arm_wc_q) cf_n = 1'b0;
      if (arm_wc_q)             wc_n = 1'b0;
      arm_cf_n = 1'b0;
      arm_wc_n = 1'b0;
    end
    if (irq_ack) cf_n = 1'b0;
    if (set_cf)  cf_n = 1'b1;
    if (set_wc)  wc_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf_q     <= 1'b0;
      wc_q     <= 1'b0;
      arm_cf_q <= 1'b0;
      arm_wc_q <= 1'b0;
    end else begin
      cf_q     <= cf_n;
      wc_q     <= wc_n;
      arm_cf_q <= arm_cf_n;
      arm_wc_q <= arm_wc_n;
    end
  end

  assign cf = cf_q;
  assign wc = wc_q;
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
  import spi_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         addr,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [FRAME_W-1:0] wdata,
  output logic [FRAME_W-1:0] rdata,
  input  logic               gie,
  input  logic               irq_ack,
  output logic               irq,
  output logic               sck_o,
  input  logic               sck_i,
  output logic               mosi_o,
  input  logic               mosi_i,
  output logic               miso_o,
  input  logic               miso_i,
  input  logic               ss_n_i,
  output logic               ss_n_o
);
  localparam int RS_STAGES = 2;

  logic [RS_STAGES-1:0] rst_pipe_q;
  logic                 rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RS_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[RS_STAGES-1];

  logic [FRAME_W-1:0] ctrl_q, ctrl_n;
  logic               dbl_q, dbl_n;
  logic               en, ms, ssi, irq_en;
  logic               wr_ctrl, wr_stat, wr_data, stat_rd, data_acc;
  logic               busy, m_busy, eng_done, ss_fall, tick, load;
  logic               set_cf, set_wc, cf, wc, sd;
  logic [FRAME_W-1:0] shreg;

  always_comb begin
    en       = ctrl_q[CB_ENABLE];
    ms       = ctrl_q[CB_MASTER];
    ssi      = ctrl_q[CB_SS_IN];
    irq_en   = ctrl_q[CB_IRQ_EN];
    wr_ctrl  = wr_en && (addr == ADR_CTRL);
    wr_stat  = wr_en && (addr == ADR_STAT);
    wr_data  = wr_en && (addr == ADR_DATA);
    stat_rd  = rd_en && (addr == ADR_STAT);
    data_acc = (rd_en || wr_en) && (addr == ADR_DATA);
    load     = wr_data && !busy && en;
    set_wc   = wr_data && busy;
    set_cf   = eng_done || (en && ms && ssi && ss_fall);
    ctrl_n   = wr_ctrl ? wdata : ctrl_q;
    dbl_n    = wr_stat ? wdata[0] : dbl_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q <= '0;
      dbl_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      dbl_q  <= dbl_n;
    end
  end

  spi_ctl_rate u_rate (
    .clk   (clk),
    .rst_n (rst_s_n),
    .run   (m_busy),
    .dbl   (dbl_q),
    .rate  (ctrl_q[1:0]),
    .tick  (tick)
  );

  spi_ctl_engine #(.DW(FRAME_W)) u_eng (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .en      (en),
    .ms      (ms),
    .load    (load),
    .ldata   (wdata),
    .tick    (tick),
    .miso_i  (miso_i),
    .sck_i   (sck_i),
    .mosi_i  (mosi_i),
    .ss_n_i  (ss_n_i),
    .busy    (busy),
    .m_busy  (m_busy),
    .done    (eng_done),
    .ss_fall (ss_fall),
    .shreg   (shreg),
    .sck_o   (sck_o),
    .sd_o    (sd)
  );

  spi_ctl_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .stat_rd  (stat_rd),
    .data_acc (data_acc),
    .irq_ack  (irq_ack),
    .set_cf   (set_cf),
    .set_wc   (set_wc),
    .cf       (cf),
    .wc       (wc)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        ADR_CTRL: rdata = ctrl_q;
        ADR_STAT: rdata = {cf, wc, {(FRAME_W-3){1'b0}}, dbl_q};
        ADR_DATA: rdata = shreg;
        default:  rdata = '0;
      endcase
    end
  end

  assign irq    = cf && irq_en && gie;
  assign mosi_o = sd;
  assign miso_o = sd;
  assign ss_n_o = (en && ms && !ssi) ? !m_busy : 1'b1;
endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk (
  input logic       clk,
  input logic       rst_s_n,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic       gie,
  input logic       irq_ack,
  input logic       irq,
  input logic       cf,
  input logic       wc,
  input logic       set_cf,
  input logic       eng_done,
  input logic       busy,
  input logic       m_busy,
  input logic       sck_o
);
  p_done_sets_flag_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    eng_done |=> cf);

  p_no_irq_without_gie_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    !gie |-> !irq);

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (irq_ack && !set_cf) |=> !cf);

  p_collision_sets_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && addr == 2'd2 && busy) |=> wc);

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_en && addr == 2'd1) |-> (rdata[5:1] == 5'd0));

  p_sck_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !m_busy |-> !sck_o);
endmodule

bind spi_ctl spi_ctl_chk u_chk (
  .clk      (clk),
  .rst_s_n  (rst_s_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rdata    (rdata),
  .gie      (gie),
  .irq_ack  (irq_ack),
  .irq      (irq),
  .cf       (cf),
  .wc       (wc),
  .set_cf   (set_cf),
  .eng_done (eng_done),
  .busy     (busy),
  .m_busy   (m_busy),
  .sck_o    (sck_o)
);

// File: tb/test_spi_ctl.sv
`timescale 1ns/1ps
module test_spi_ctl;
  logic       clk;
  logic       rst_n;
  logic [1:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wdata, rdata;
  logic       gie, irq_ack, irq;
  logic       sck_o, sck_i, mosi_o, mosi_i, miso_o, miso_i, ss_n_i, ss_n_o;

  int total = 0;
  int bad   = 0;

  spi_ctl i_spi_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .gie(gie), .irq_ack(irq_ack), .irq(irq),
    .sck_o(sck_o), .sck_i(sck_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_i(miso_i), .ss_n_i(ss_n_i), .ss_n_o(ss_n_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // external slave model for master mode
  logic [7:0] ext_tx, ext_cap;
  always @(negedge sck_o) ext_tx <= {ext_tx[6:0], 1'b0};
  always @(posedge sck_o) ext_cap <= {ext_cap[6:0], mosi_o};
  assign miso_i = ext_tx[7];

  // SCK rise timing
  int cyc = 0, r_last = 0, r_prev = 0;
  logic sck_prev = 1'b0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (sck_o && !sck_prev) begin
      r_prev = r_last;
      r_last = cyc;
    end
    sck_prev = sck_o;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  function automatic int exp_period(input logic dbl, input logic [1:0] rate);
    int b;
    b = (rate == 2'd0) ? 4 : (rate == 2'd1) ? 16 : (rate == 2'd2) ? 64 : 128;
    return dbl ? b / 2 : b;
  endfunction

  task automatic wait_cf(output logic [7:0] st);
    st = 8'h00;
    for (int k = 0; k < 4000; k++) begin
      bus_rd(2'd1, st);
      if (st[7]) break;
    end
  endtask

  task automatic master_xfer(input logic dbl, input logic [1:0] rate,
                             input logic [7:0] tx, input logic [7:0] sb,
                             input logic collide);
    logic [7:0] st, rx;
    bus_wr(2'd1, {7'd0, dbl});
    bus_wr(2'd0, 8'h50 | {6'd0, rate});
    ext_tx = sb; ext_cap = 8'h00;
    bus_wr(2'd2, tx);
    check("R12 select low during frame", ss_n_o, 0);
    if (collide) begin
      repeat (10) @(negedge clk);
      bus_wr(2'd2, ~tx);
    end
    wait_cf(st);
    check("R1 completion flag", st[7], 1);
    check("R6 collision flag", st[6], collide);
    check("R9 sck period", r_last - r_prev, exp_period(dbl, rate));
    check("R10 mosi byte", ext_cap, tx);
    check("R12 select high after frame", ss_n_o, 1);
    bus_rd(2'd2, rx);
    check("R10 received byte", rx, sb);
    bus_rd(2'd1, st);
    check("R5 R7 flags cleared", st, {7'd0, dbl});
  endtask

  task automatic slave_xfer(input logic [7:0] mb, input logic [7:0] sb);
    logic [7:0] st, rx, cap;
    cap = 8'h00;
    bus_wr(2'd0, 8'h40);
    bus_wr(2'd2, sb);
    @(negedge clk); ss_n_i = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      mosi_i = mb[i];
      repeat (4) @(negedge clk);
      cap = {cap[6:0], miso_o};
      sck_i = 1'b1;
      repeat (4) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(2'd1, st);
    check("R11 R1 slave completion", st[7], 1);
    bus_rd(2'd2, rx);
    check("R11 slave received", rx, mb);
    check("R11 slave sent", cap, sb);
    bus_rd(2'd1, st);
    check("R5 slave flag cleared", st[7], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; addr = 2'd0; wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00;
    gie = 1'b0; irq_ack = 1'b0; sck_i = 1'b0; mosi_i = 1'b0; ss_n_i = 1'b1;
    ext_tx = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 reset state
    bus_rd(2'd0, v); check("R8 ctrl reset", v, 0);
    bus_rd(2'd1, v); check("R8 status reset", v, 0);
    bus_rd(2'd2, v); check("R8 data reset", v, 0);
    check("R2 irq reset", irq, 0);
    check("R12 select idle", ss_n_o, 1);
    check("R10 sck idle", sck_o, 0);

    // R8 status write mask
    bus_wr(2'd1, 8'hFF);
    bus_rd(2'd1, v); check("R8 status writable bit only", v, 8'h01);
    bus_wr(2'd1, 8'h00);
    bus_rd(2'd1, v); check("R8 double speed cleared", v, 8'h00);

    // R9 R10 sweep of all rate settings
    for (int d = 0; d < 2; d++)
      for (int r = 0; r < 4; r++)
        master_xfer(d[0], r[1:0], 8'hA5 ^ 8'(d*53 + r*37), 8'h3C ^ 8'(r*71 + d*19), 1'b0);

    // R6 R7 collision
    master_xfer(1'b0, 2'd1, 8'h96, 8'h5A, 1'b1);

    // R2 R4 interrupt
    bus_wr(2'd1, 8'h01);
    bus_wr(2'd0, 8'hD0);
    gie = 1'b0;
    bus_wr(2'd2, 8'h11);
    repeat (40) @(negedge clk);
    check("R2 irq masked by gie", irq, 0);
    gie = 1'b1; #1;
    check("R2 irq raised", irq, 1);
    @(negedge clk); irq_ack = 1'b1;
    @(posedge clk); #1; irq_ack = 1'b0;
    check("R4 irq dropped after ack", irq, 0);
    bus_rd(2'd1, v); check("R4 flag cleared by ack", v[7], 0);

    // R5 status read with flag clear does not arm
    bus_rd(2'd1, v); check("R5 flag clear before frame", v[7], 0);
    bus_wr(2'd2, 8'h22);
    repeat (40) @(negedge clk);
    bus_rd(2'd2, v);
    bus_rd(2'd1, v); check("R5 unarmed access keeps flag", v[7], 1);
    bus_rd(2'd2, v);
    bus_rd(2'd1, v); check("R5 armed access clears flag", v[7], 0);
    gie = 1'b0;

    // R3 select fault in master mode
    bus_wr(2'd0, 8'h58);
    check("R12 select high when used as input", ss_n_o, 1);
    @(negedge clk); ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    bus_rd(2'd1, v); check("R3 select low sets flag", v[7], 1);
    @(negedge clk); irq_ack = 1'b1;
    @(posedge clk); #1; irq_ack = 1'b0;
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    bus_rd(2'd1, v); check("R3 R4 flag stays clear after release", v[7], 0);

    // R11 slave mode
    slave_xfer(8'hC3, 8'h3C);
    slave_xfer(8'h81, 8'h7E);
    slave_xfer(8'h00, 8'hFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule